// File: doc/BRIEF.md
# Jack Sense Interrupt Controller

This block watches two asynchronous jack-detect pins. Each pin is brought into the clock domain and can then be qualified by an optional long-high timer. The qualified level drives three things. First, a per-pin interrupt flag, which is active only when that pin is switched to interrupt mode. Second, a down-mix request. Third, a spread request. The block also hands a 3-bit mute selection field to an external decoder.

Software reaches everything through one 16-bit control register with a write strobe and a combinational read image. The register holds the flags, the per-pin mode and timer bits, the mute selector and the per-function enables. It also reports the synchronized pin levels. The two flags are ORed into a single system interrupt line.

Top module: `jsic_top`

## Requirements
- R1: After synchronous reset the register reads 0000h, and `irq`, `dmix_req`, `spread_req` and `mute_sel` are all 0.
- R2: Bits 4 (pin 0 mode), 5 (pin 1 mode), 6 (pin 0 timer), 7 (pin 1 timer), 10 to 12 (mute selector), 13 (pin 0 down-mix enable), 14 (pin 1 down-mix enable, storage only) and 15 (spread enable) read back the last value written. Bits 8 and 9 always read 0.
- R3: Bit 2 reads the level of pin 0 and bit 3 reads the level of pin 1, each after a two-flop synchronizer. A level change therefore shows on the second clock edge after it. Writes to bits 2 and 3 are ignored.
- R4: Bit 0 (pin 0 flag) and bit 1 (pin 1 flag) are sticky. Writing 0 clears a flag and writing 1 sets it.
- R5: `irq` equals bit 0 OR bit 1 of the register.
- R6: When a pin's mode bit is 1, a rising edge of that pin's qualified level sets its flag one clock after the qualified level rises. With the mode bit at 0, no hardware set occurs.
- R7: A hardware flag set and a software write of 0 to the same flag in the same cycle leave the flag set.
- R8: With the timer bit at 0, the qualified level equals the synchronized level. With the timer bit at 1, the qualified level rises only after the synchronized level has been high for more than CLK_KHZ*QUAL_MS clocks. Any low cycle restarts the count.
- R9: `dmix_req` is 1 exactly when bit 13 is 1 and pin 0's qualified level is high.
- R10: `spread_req` is 1 exactly when bit 15 is 1 and both qualified levels are high.
- R11: `mute_sel` equals register bits 12 down to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| jack_pin | input | 2 | Asynchronous jack-detect pins (bit 0 = pin 0) |
| rdata | output | 16 | Register read image |
| irq | output | 1 | System interrupt |
| dmix_req | output | 1 | Down-mix request |
| spread_req | output | 1 | Spread request |
| mute_sel | output | 3 | Raw mute selector field |

## Verification
A wrong stored bit shows up on `rdata` in the cycle after the write that should have set it. Because `irq`, `mute_sel` and both request outputs are combinational from the register, a corrupted flag or enable also appears at once on those pins.

A broken synchronizer or qualifier shows as a shift in the clock edge at which the status bits or `dmix_req` change after a pin moves. A lost edge detection shows as a missing flag one clock after the qualified rise. The bench samples every one of these cycles exactly.

// File: rtl/jsic_pkg.sv
package jsic_pkg;

    localparam int NPIN = 2;

    typedef struct packed {
        logic            sprd_en;
        logic            dmx1_en;
        logic            dmx0_en;
        logic [2:0]      mute;
        logic [NPIN-1:0] tmr;
        logic [NPIN-1:0] md;
        logic [NPIN-1:0] flag;
    } jsic_cfg_t;

    function automatic jsic_cfg_t cfg_from_word(input logic [15:0] w);
        jsic_cfg_t c;
        c.flag    = w[1:0];
        c.md      = w[5:4];
        c.tmr     = w[7:6];
        c.mute    = w[12:10];
        c.dmx0_en = w[13];
        c.dmx1_en = w[14];
        c.sprd_en = w[15];
        return c;
    endfunction

    function automatic logic [15:0] word_from_cfg(input jsic_cfg_t c,
                                                  input logic [NPIN-1:0] lvl);
        return {c.sprd_en, c.dmx1_en, c.dmx0_en, c.mute, 2'b00,
                c.tmr, c.md, lvl, c.flag};
    endfunction

endpackage

// File: rtl/jsic_sync.sv
module jsic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/jsic_qual.sv
module jsic_qual #(
    parameter int TC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic tmr_en,
    output logic qual
);
    localparam int CW = $clog2(TC + 1);
    localparam logic [CW-1:0] TC_V = CW'(TC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !level)  cnt <= '0;
        else if (cnt != TC_V) cnt <= cnt + 1'b1;
    end

    assign qual = level && (!tmr_en || (cnt == TC_V));
endmodule

// File: rtl/jsic_pin.sv
module jsic_pin #(
    parameter int TC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    input  logic tmr_en,
    output logic level,
    output logic qual,
    output logic rise
);
    logic qual_d;

    jsic_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(pin_async), .q(level)
    );

    jsic_qual #(.TC(TC)) u_qual (
        .clk(clk), .rst(rst), .level(level), .tmr_en(tmr_en), .qual(qual)
    );

    always_ff @(posedge clk) begin
        if (rst) qual_d <= 1'b0;
        else     qual_d <= qual;
    end

    assign rise = qual && !qual_d;
endmodule

// File: rtl/jsic_top.sv
module jsic_top
    import jsic_pkg::*;
#(
    parameter int CLK_KHZ = 24576,
    parameter int QUAL_MS = 278
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic [1:0]  jack_pin,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        dmix_req,
    output logic        spread_req,
    output logic [2:0]  mute_sel
);
    localparam int TC = CLK_KHZ * QUAL_MS;

    jsic_cfg_t       cfg;
    logic [NPIN-1:0] lvl;
    logic [NPIN-1:0] qual;
    logic [NPIN-1:0] rise;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        jsic_pin #(.TC(TC)) u_pin (
            .clk(clk), .rst(rst), .pin_async(jack_pin[i]),
            .tmr_en(cfg.tmr[i]), .level(lvl[i]), .qual(qual[i]), .rise(rise[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_en) cfg <= cfg_from_word(wdata);
            for (int i = 0; i < NPIN; i++) begin
                if (cfg.md[i] && rise[i]) cfg.flag[i] <= 1'b1;
            end
        end
    end

    assign rdata      = word_from_cfg(cfg, lvl);
    assign irq        = |cfg.flag;
    assign dmix_req   = cfg.dmx0_en && qual[0];
    assign spread_req = cfg.sprd_en && (&qual);
    assign mute_sel   = cfg.mute;
endmodule

// File: rtl/jsic_chk.sv
module jsic_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        irq,
    input logic        dmix_req,
    input logic        spread_req,
    input logic [2:0]  mute_sel
);
    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
        irq == (rdata[0] || rdata[1])); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rdata[0] && !(wr_en && !wdata[0])) |=> rdata[0]); // R4

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[9:8] == 2'b00); // R2

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rdata[7:4] == $past(wdata[7:4])); // R2

    AST_DMIX_GATE: assert property (@(posedge clk) disable iff (rst)
        dmix_req |-> (rdata[13] && rdata[2])); // R9

    AST_SPREAD_GATE: assert property (@(posedge clk) disable iff (rst)
        spread_req |-> (rdata[15] && rdata[2] && rdata[3])); // R10

    AST_MUTE_FIELD: assert property (@(posedge clk) disable iff (rst)
        mute_sel == rdata[12:10]); // R11
endmodule

bind jsic_top jsic_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .irq(irq), .dmix_req(dmix_req), .spread_req(spread_req), .mute_sel(mute_sel)
);

// File: tb/tb_jsic_top.sv
module tb_jsic_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 1;
    localparam int QUAL_MS    = 8;
    localparam int TC         = CLK_KHZ * QUAL_MS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [1:0]  jack_pin = '0;
    logic [15:0] rdata;
    logic        irq, dmix_req, spread_req;
    logic [2:0]  mute_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jsic_top #(.CLK_KHZ(CLK_KHZ), .QUAL_MS(QUAL_MS)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .jack_pin(jack_pin),
        .rdata(rdata), .irq(irq), .dmix_req(dmix_req), .spread_req(spread_req),
        .mute_sel(mute_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sweep(input int stride, input logic [1:0] lv);
        for (int v = 0; v < 65536; v += stride) begin
            logic [15:0] w;
            w = 16'(v);
            wr(w);
            chk("R2/R3 readback", rdata, (w & 16'hFCF3) | {12'd0, lv, 2'b00});
            chk("R4/R5 irq", irq, w[0] | w[1]);
            chk("R9/R10/R11 outputs", {dmix_req, spread_req, mute_sel},
                {w[13] & lv[0], w[15] & lv[0] & lv[1], w[12:10]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 reset rdata", rdata, 16'h0000);
        chk("R1 reset outputs", {irq, dmix_req, spread_req, mute_sel}, 6'd0);

        // R2 R3 R4 R5 R9 R10 R11: full sweep with pins low
        sweep(1, 2'b00);
        wr(16'h0000);
        chk("R4 clear by zero", rdata[1:0], 2'b00);

        // both pins high, sweep subset
        jack_pin = 2'b11;
        step(TC + 4);
        sweep(7, 2'b11);
        wr(16'h0000);
        jack_pin = 2'b00;
        step(TC + 4);

        // R3 latency on pin 1
        jack_pin[1] = 1'b1;
        @(negedge clk);
        chk("R3 pin1 level k1", rdata[3], 1'b0);
        @(negedge clk);
        chk("R3 pin1 level k2", rdata[3], 1'b1);
        jack_pin[1] = 1'b0;
        step(4);

        // R6 jack-sense mode: no hardware set; R8 untimed, R9 dmix
        wr(16'h2000);
        jack_pin[0] = 1'b1;
        @(negedge clk);
        chk("R8 untimed k1", dmix_req, 1'b0);
        @(negedge clk);
        chk("R9 dmix k2", dmix_req, 1'b1);
        step(3);
        chk("R6 no set in sense mode", rdata[0], 1'b0);
        jack_pin[0] = 1'b0;
        step(4);

        // R6 interrupt mode
        wr(16'h0010);
        jack_pin[0] = 1'b1;
        step(2);
        chk("R6 flag not yet k2", irq, 1'b0);
        @(negedge clk);
        chk("R6 flag set k3", rdata[0], 1'b1);
        chk("R5 irq from flag", irq, 1'b1);
        step(2);
        wr(16'h0010);
        chk("R4 sw clear", rdata[0], 1'b0);
        jack_pin[0] = 1'b0;
        step(4);

        // R7 collision of hardware set and software clear
        jack_pin[0] = 1'b1;
        step(2);
        wr(16'h0010);
        chk("R7 hw set wins", rdata[0], 1'b1);
        jack_pin[0] = 1'b0;
        step(3);
        wr(16'h0000);
        step(2);

        // R8 timed qualification
        wr(16'h2040);
        jack_pin[0] = 1'b1;
        for (int k = 1; k <= TC + 3; k++) begin
            @(negedge clk);
            chk("R8 timed rise", dmix_req, k >= TC + 2);
        end
        jack_pin[0] = 1'b0;
        @(negedge clk);
        jack_pin[0] = 1'b1;
        for (int k = 1; k <= TC + 3; k++) begin
            @(negedge clk);
            chk("R8 restart after low", dmix_req, k >= TC + 2);
        end
        jack_pin[0] = 1'b0;
        step(4);

        // R10 spread needs both pins
        wr(16'h8000);
        jack_pin = 2'b01;
        step(3);
        chk("R10 one pin only", spread_req, 1'b0);
        jack_pin = 2'b11;
        step(2);
        chk("R10 both pins", spread_req, 1'b1);
        jack_pin = 2'b10;
        step(2);
        chk("R10 pin0 dropped", spread_req, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule